// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of an integrating dual-slope analog-to-digital converter. A start request clears an internal counter and routes the unknown input to an external integrator. The input is integrated for a fixed number of clocks. The block then switches the integrator to the negative reference and counts again from zero. It stops when the external comparator reports that the integrator output has returned to zero.

The count held when the comparator trips becomes the conversion result, and it is proportional to the input. A one-cycle done strobe marks the result. If the comparator never trips before the counter reaches full scale, the result saturates to all ones and an overrange flag is raised. The integrator, the comparator and the analog switches are outside the block.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `selRef`, `cntEnable`, `donePulse` and `overRange` are 0 and `resultCode` is 0.
- R2: A `startReq` sampled high while idle makes the block busy in the next cycle, with `selRef` = 0 (unknown input selected) and `cntEnable` = 1.
- R3: A `startReq` sampled high while busy is ignored: the running conversion neither restarts nor changes its phase lengths or result, and it produces exactly one `donePulse`.
- R4: The integrate phase, with `selRef` = 0, lasts exactly `INT_COUNT` cycles, whatever the comparator reports during it (default `INT_COUNT` = 2^`RES_BITS`).
- R5: After the integrate phase, `selRef` = 1 and the counter restarts from zero. In the first de-integrate cycle in which `cmpBelow` is sampled low, with the count at k, the result becomes k.
- R6: `resultCode` and `overRange` change only in a cycle where `donePulse` is 1, and hold their values otherwise.
- R7: `donePulse` is high for exactly one cycle per conversion, in the same cycle the new result appears. In that cycle `busy`, `selRef` and `cntEnable` are already 0.
- R8: If `cmpBelow` is still high at count 2^`RES_BITS`-1 in the de-integrate phase, the result is all ones and `overRange` = 1. A trip at exactly that count gives all ones with `overRange` = 0.
- R9: `cntEnable` (the counter clock enable) is high in every cycle of both phases and low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request to begin a conversion |
| cmpBelow | input | 1 | Comparator: 1 while the integrator has not yet returned to zero |
| selRef | output | 1 | Integrator source: 0 unknown input, 1 negative reference |
| cntEnable | output | 1 | Counter clock enable, high during both phases |
| busy | output | 1 | Conversion in progress |
| resultCode | output | RES_BITS | Latched conversion result |
| overRange | output | 1 | Latched flag: result saturated at full scale |
| donePulse | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench models the integrator as an accumulator. It adds the input value once per integrate cycle and removes `INT_COUNT` units per de-integrate cycle, so every integer input from zero up to a few codes past full scale must come back as the same code. Zero input shows that the comparator is ignored during integration and that a trip in the first reference cycle yields 0. The input equal to full scale separates a trip at full scale from the saturating overrange case just above it. Extra start requests, placed once in each phase, show whether the sequencer restarts, stretches a phase or emits a second strobe.

// File: rtl/dss_pkg.sv
`timescale 1ns/1ps
package dss_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_INTEG = 2'd1,
    PH_DEINT = 2'd2
  } dss_phase_t;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic latchCnt;
    logic latchSat;
  } dss_strobe_t;

endpackage

// File: rtl/dss_ctrl.sv
`timescale 1ns/1ps
module dss_ctrl
  import dss_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startReq,
  input  logic        cmpBelow,
  input  logic        cntAtIntEnd,
  input  logic        cntFull,
  output dss_strobe_t stb,
  output logic        selRef,
  output logic        cntEnable,
  output logic        busy
);

  dss_phase_t phase, phaseNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    stb       = '0;
    unique case (phase)
      PH_IDLE: begin
        if (startReq) begin
          stb.clrCnt = 1'b1;
          phaseNext  = PH_INTEG;
        end
      end
      PH_INTEG: begin
        // comparator deliberately not consulted in this phase
        if (cntAtIntEnd) begin
          stb.clrCnt = 1'b1;
          phaseNext  = PH_DEINT;
        end else begin
          stb.incCnt = 1'b1;
        end
      end
      PH_DEINT: begin
        if (!cmpBelow) begin
          stb.latchCnt = 1'b1;
          phaseNext    = PH_IDLE;
        end else if (cntFull) begin
          stb.latchSat = 1'b1;
          phaseNext    = PH_IDLE;
        end else begin
          stb.incCnt = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  assign selRef    = (phase == PH_DEINT);
  assign busy      = (phase != PH_IDLE);
  assign cntEnable = busy;

endmodule

// File: rtl/dss_datapath.sv
`timescale 1ns/1ps
module dss_datapath
  import dss_pkg::*;
#(
  parameter int RES_BITS  = 8,
  parameter int INT_COUNT = 2 ** RES_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dss_strobe_t         stb,
  output logic                cntAtIntEnd,
  output logic                cntFull,
  output logic [RES_BITS-1:0] resultCode,
  output logic                overRange,
  output logic                donePulse
);

  localparam int INT_W = (INT_COUNT > 1) ? $clog2(INT_COUNT) : 1;
  localparam int CNT_W = (INT_W > RES_BITS) ? INT_W : RES_BITS;
  localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(INT_COUNT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (stb.clrCnt) cnt <= '0;
    else if (stb.incCnt) cnt <= cnt + 1'b1;
  end

  assign cntAtIntEnd = (cnt == INT_LAST);
  assign cntFull     = (cnt[RES_BITS-1:0] == {RES_BITS{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultCode <= '0;
      overRange  <= 1'b0;
      donePulse  <= 1'b0;
    end else begin
      donePulse <= stb.latchCnt | stb.latchSat;
      if (stb.latchSat) begin
        resultCode <= {RES_BITS{1'b1}};
        overRange  <= 1'b1;
      end else if (stb.latchCnt) begin
        resultCode <= cnt[RES_BITS-1:0];
        overRange  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dual_slope_seq.sv
`timescale 1ns/1ps
module dual_slope_seq
  import dss_pkg::*;
#(
  parameter int RES_BITS  = 8,
  parameter int INT_COUNT = 2 ** RES_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startReq,
  input  logic                cmpBelow,
  output logic                selRef,
  output logic                cntEnable,
  output logic                busy,
  output logic [RES_BITS-1:0] resultCode,
  output logic                overRange,
  output logic                donePulse
);

  dss_strobe_t stb;
  logic        cntAtIntEnd;
  logic        cntFull;

  dss_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .startReq    (startReq),
    .cmpBelow    (cmpBelow),
    .cntAtIntEnd (cntAtIntEnd),
    .cntFull     (cntFull),
    .stb         (stb),
    .selRef      (selRef),
    .cntEnable   (cntEnable),
    .busy        (busy)
  );

  dss_datapath #(
    .RES_BITS  (RES_BITS),
    .INT_COUNT (INT_COUNT)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .cntAtIntEnd (cntAtIntEnd),
    .cntFull     (cntFull),
    .resultCode  (resultCode),
    .overRange   (overRange),
    .donePulse   (donePulse)
  );

endmodule

// File: rtl/dss_checker.sv
`timescale 1ns/1ps
module dss_checker #(
  parameter int RES_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                startReq,
  input logic                cmpBelow,
  input logic                selRef,
  input logic                cntEnable,
  input logic                busy,
  input logic [RES_BITS-1:0] resultCode,
  input logic                overRange,
  input logic                donePulse
);

  assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |=> !donePulse);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    donePulse |-> (!busy && !selRef));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !donePulse |-> ($stable(resultCode) && $stable(overRange)));

  assert_overrange_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overRange |-> (resultCode == {RES_BITS{1'b1}}));

  assert_trip_before_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (donePulse && !overRange) |-> $past(!cmpBelow));

  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (selRef && startReq) |=> !(busy && !selRef));

  assert_enable_tracks_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cntEnable == busy);

  assert_ref_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selRef) |-> $past(busy));

endmodule

bind dual_slope_seq dss_checker #(.RES_BITS(RES_BITS)) u_dss_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .startReq   (startReq),
  .cmpBelow   (cmpBelow),
  .selRef     (selRef),
  .cntEnable  (cntEnable),
  .busy       (busy),
  .resultCode (resultCode),
  .overRange  (overRange),
  .donePulse  (donePulse)
);

// File: tb/sim_dual_slope_seq.sv
`timescale 1ns/1ps
module sim_dual_slope_seq;

  localparam int RB   = 6;
  localparam int INTC = 64;
  localparam int FULL = (1 << RB) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          startReq = 1'b0;
  logic          cmpBelow = 1'b0;
  logic          selRef, cntEnable, busy, overRange, donePulse;
  logic [RB-1:0] resultCode;

  int compared = 0;
  int mismatched = 0;
  int vinCur = 0;
  int acc = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dual_slope_seq #(.RES_BITS(RB), .INT_COUNT(INTC)) u0 (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .cmpBelow(cmpBelow),
    .selRef(selRef), .cntEnable(cntEnable), .busy(busy),
    .resultCode(resultCode), .overRange(overRange), .donePulse(donePulse)
  );

  // integrator and comparator model, updated away from the active edge
  always @(negedge clk) begin
    cmpBelow = (acc > 0);
    if (!busy)        acc = 0;
    else if (!selRef) acc = acc + vinCur;
    else              acc = acc - INTC;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finishRun();
    end
  end

  // one conversion; poke adds stray start requests in both phases
  task automatic runConv(input int vin, input bit poke);
    int integLen = 0;
    int doneCnt = 0;
    int n = 0;
    int expRes;
    bit expOver;
    bit done = 0;
    expOver = (vin > FULL);
    expRes  = expOver ? FULL : vin;
    vinCur  = vin;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    check(busy && !selRef && cntEnable, "R2", {busy, selRef, cntEnable}, 3'b101);
    while (!done) begin
      if (cntEnable && !selRef) integLen++;
      if (busy != cntEnable) check(1'b0, "R9", cntEnable, busy);
      startReq = poke && (n == 10 || n == INTC + 1);
      if (startReq && !busy) startReq = 1'b0;
      @(negedge clk);
      n++;
      if (donePulse) begin
        doneCnt++;
        done = 1;
      end
      if (n > 4 * INTC + 20) begin
        check(1'b0, "R5 timeout", n, 0);
        return;
      end
    end
    startReq = 1'b0;
    check(integLen == INTC, "R4", integLen, INTC);
    check(int'(resultCode) == expRes, poke ? "R3 result" : (expOver ? "R8 result" : "R5"),
          resultCode, expRes);
    check(overRange == expOver, "R8 flag", overRange, expOver);
    check(!busy && !selRef && !cntEnable, "R7 idle at done", busy, 0);
    @(negedge clk);
    check(!donePulse, "R7 single pulse", donePulse, 0);
    check(int'(resultCode) == expRes && overRange == expOver, "R6 hold", resultCode, expRes);
    if (poke) check(doneCnt == 1 && !busy, "R3 no restart", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !selRef && !cntEnable && !donePulse && !overRange && resultCode == '0,
          "R1", {busy, selRef, cntEnable, donePulse, overRange}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && resultCode == '0, "R1 after release", busy, 0);
    // sweep every code, the full-scale boundary and a few overrange inputs
    for (int v = 0; v <= FULL + 4; v++) runConv(v, 1'b0);
    // stray starts in both phases
    runConv(20, 1'b1);
    runConv(0, 1'b1);
    runConv(FULL + 2, 1'b1);
    // result holds while idle with input changing
    vinCur = 5;
    repeat (20) @(negedge clk);
    check(overRange && int'(resultCode) == FULL && !busy, "R6 idle hold", resultCode, FULL);
    runConv(FULL, 1'b0);
    check(!overRange, "R8 trip at full scale", overRange, 0);
    finishRun();
  end

endmodule